// File: doc/BRIEF.md
# Asynchronous SRAM write sequencer

This block turns a one-cycle host write request into a complete write cycle on an asynchronous static RAM bus. The memory's write-enable strobe controls the write. The host presents an address, a 16-bit word, two byte enables and a request pulse. The sequencer captures them and ignores the request line until the cycle is over. It then drives chip enable, chip select, write enable, the two byte selects and the data bus in a fixed order. A one-cycle done pulse marks the end of the cycle.

Every interval is a parameter in nanoseconds. Each is converted to clock cycles at elaboration by rounding up against the clock period parameter, with a floor of one cycle for any nonzero value. The write pulse is stretched far enough that data is driven only after the memory's outputs have gone high-impedance, and still stays on the bus long enough before the strobe rises. A per-request mode input picks between byte-selectable writes and whole-word writes. In whole-word mode the byte selects are held inactive.

The cycle passes through five states. IDLE waits for a request. SETUP lowers chip enable with the strobe still high. PULSE holds the strobe low and turns the data driver on partway through. RECOVER raises the strobe with chip enable still low. DONE raises chip enable and pulses done. The transitions are IDLE→SETUP (request seen), SETUP→PULSE, PULSE→RECOVER and RECOVER→DONE, each taken when that state's cycle count runs out, and DONE→IDLE after one cycle.

Top module: `sram_wr_seq`

## Requirements
- R1: The strobe `sram_we_n` is low only while `sram_ce1_n` is low and `sram_cs2` is high. The strobe rises one RECOVER phase before chip enable rises.
- R2: The strobe stays low for PULSE_CYC cycles, which is at least ceil(60 ns / period). With the defaults (10 ns clock) it is low for exactly 7 cycles.
- R3: Chip enable falls SETUP_CYC cycles before the strobe falls and stays low for SETUP+PULSE+RECOVER cycles, at least ceil(70 ns / period) before the strobe rises. Defaults: chip enable low for 9 cycles, strobe falls 1 cycle after chip enable.
- R4: `sram_addr` equals the captured request address during the whole cycle and does not change while chip enable is low.
- R5: When `wide_sel` was high at the request, `sram_ub_n` = !be[1] and `sram_lb_n` = !be[0] while chip enable is low. When it was low, both stay high. Both stay high whenever chip enable is high.
- R6: `sram_doe` is high only while the strobe is low. It turns on WHZ_CYC cycles after the strobe falls (3 by default) and stays on through the strobe's last low cycle, for at least ceil(35 ns / period) cycles (4 by default). While it is on, `sram_dout` equals the captured request data.
- R7: `done` is a single-cycle pulse, in the DONE state, 10 cycles after the clock edge that samples the request (defaults). Chip enable is high during that cycle.
- R8: A request raised while a cycle is in progress is ignored. It starts no further cycle and does not change the address or data.
- R9: After reset, chip enable and the strobe are high, chip select is low, both byte selects are high, and `sram_doe` and `done` are low.
- R10: The time from one address capture to the next is at least WC_CYC = ceil(85 ns / period) cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req | input | 1 | One-cycle write request, sampled in IDLE |
| req_addr | input | ADDR_W | Write address |
| req_data | input | DATA_W | Write data |
| req_be | input | 2 | Byte enables, bit 1 upper, bit 0 lower |
| wide_sel | input | 1 | High: byte selects follow req_be; low: whole word |
| done | output | 1 | End-of-cycle pulse |
| sram_addr | output | ADDR_W | Memory address |
| sram_ce1_n | output | 1 | Chip enable, active low |
| sram_cs2 | output | 1 | Chip select, active high |
| sram_we_n | output | 1 | Write strobe, active low |
| sram_ub_n | output | 1 | Upper byte select, active low |
| sram_lb_n | output | 1 | Lower byte select, active low |
| sram_dout | output | DATA_W | Data to the memory bus |
| sram_doe | output | 1 | Data bus driver enable |

## Verification
A state register stuck or skipped shows at the pins within a single write. Chip enable stays low, or the strobe never falls, and done fails to appear in the tenth cycle after the request. A wrong phase counter shows as a strobe, chip-enable or data-drive window that is a cycle longer or shorter than expected. The bench counts each of these windows cycle by cycle, and also catches the data driver turning on inside the high-impedance window or overlapping a high strobe.

// File: rtl/sram_wr_pkg.sv
package sram_wr_pkg;

    typedef enum logic [2:0] {
        ST_IDLE    = 3'd0,
        ST_SETUP   = 3'd1,
        ST_PULSE   = 3'd2,
        ST_RECOVER = 3'd3,
        ST_DONE    = 3'd4
    } wr_state_e;

    // nanoseconds to whole cycles, rounded up, floor of 1 when nonzero
    function automatic int ns_to_cyc(input int ns, input int period);
        int c;
        c = (ns + period - 1) / period;
        if (ns > 0 && c < 1) c = 1;
        return c;
    endfunction

    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

    function automatic int bits_for(input int v);
        int b;
        b = 1;
        while ((1 << b) <= v) b++;
        return b;
    endfunction

endpackage

// File: rtl/sram_wr_fsm.sv
module sram_wr_fsm
    import sram_wr_pkg::*;
#(
    parameter int SETUP_CYC = 1,
    parameter int PULSE_CYC = 7,
    parameter int REC_CYC   = 1,
    parameter int WHZ_CYC   = 3,
    parameter int CNT_W     = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic req,
    output logic capture,
    output logic ce_act,
    output logic we_act,
    output logic drive,
    output logic done
);

    wr_state_e         state, state_nx;
    logic [CNT_W-1:0]  cnt;
    logic              last;

    localparam logic [CNT_W-1:0] SETUP_LAST = CNT_W'(SETUP_CYC - 1);
    localparam logic [CNT_W-1:0] PULSE_LAST = CNT_W'(PULSE_CYC - 1);
    localparam logic [CNT_W-1:0] REC_LAST   = CNT_W'(REC_CYC - 1);
    localparam logic [CNT_W-1:0] WHZ_CNT    = CNT_W'(WHZ_CYC);

    always_comb begin
        unique case (state)
            ST_SETUP:   last = (cnt == SETUP_LAST);
            ST_PULSE:   last = (cnt == PULSE_LAST);
            ST_RECOVER: last = (cnt == REC_LAST);
            default:    last = 1'b1;
        endcase
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:    if (req)  state_nx = ST_SETUP;
            ST_SETUP:   if (last) state_nx = ST_PULSE;
            ST_PULSE:   if (last) state_nx = ST_RECOVER;
            ST_RECOVER: if (last) state_nx = ST_DONE;
            ST_DONE:              state_nx = ST_IDLE;
            default:              state_nx = ST_IDLE;
        endcase
    end

    // state register and phase counter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            cnt   <= '0;
        end else begin
            state <= state_nx;
            cnt   <= (state_nx != state) ? '0 : cnt + 1'b1;
        end
    end

    // outputs decoded from state only
    always_comb begin
        capture = 1'b0;
        ce_act  = 1'b0;
        we_act  = 1'b0;
        drive   = 1'b0;
        done    = 1'b0;
        unique case (state)
            ST_IDLE:    capture = req;
            ST_SETUP:   ce_act  = 1'b1;
            ST_PULSE: begin
                ce_act = 1'b1;
                we_act = 1'b1;
                drive  = (cnt >= WHZ_CNT);
            end
            ST_RECOVER: ce_act  = 1'b1;
            ST_DONE:    done    = 1'b1;
            default:    ;
        endcase
    end

endmodule

// File: rtl/sram_wr_dpath.sv
module sram_wr_dpath #(
    parameter int ADDR_W = 18,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              capture,
    input  logic              ce_act,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_data,
    input  logic [1:0]        req_be,
    input  logic              wide_sel,
    output logic [ADDR_W-1:0] addr_q,
    output logic [DATA_W-1:0] data_q,
    output logic              ub_n,
    output logic              lb_n
);

    logic [1:0] be_q;
    logic       wide_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q <= '0;
            data_q <= '0;
            be_q   <= '0;
            wide_q <= 1'b0;
        end else if (capture) begin
            addr_q <= req_addr;
            data_q <= req_data;
            be_q   <= req_be;
            wide_q <= wide_sel;
        end
    end

    always_comb begin
        ub_n = !(ce_act && wide_q && be_q[1]);
        lb_n = !(ce_act && wide_q && be_q[0]);
    end

endmodule

// File: rtl/sram_wr_seq.sv
module sram_wr_seq
    import sram_wr_pkg::*;
#(
    parameter int ADDR_W   = 18,
    parameter int DATA_W   = 16,
    parameter int CLK_NS   = 10,
    parameter int T_WP_NS  = 60,
    parameter int T_WC_NS  = 85,
    parameter int T_AW_NS  = 70,
    parameter int T_DW_NS  = 35,
    parameter int T_WHZ_NS = 25
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_data,
    input  logic [1:0]        req_be,
    input  logic              wide_sel,
    output logic              done,
    output logic [ADDR_W-1:0] sram_addr,
    output logic              sram_ce1_n,
    output logic              sram_cs2,
    output logic              sram_we_n,
    output logic              sram_ub_n,
    output logic              sram_lb_n,
    output logic [DATA_W-1:0] sram_dout,
    output logic              sram_doe
);

    localparam int WP_CYC    = ns_to_cyc(T_WP_NS, CLK_NS);
    localparam int WC_CYC    = ns_to_cyc(T_WC_NS, CLK_NS);
    localparam int AW_CYC    = ns_to_cyc(T_AW_NS, CLK_NS);
    localparam int DW_CYC    = ns_to_cyc(T_DW_NS, CLK_NS);
    localparam int WHZ_CYC   = ns_to_cyc(T_WHZ_NS, CLK_NS);
    localparam int PULSE_CYC = imax(WP_CYC, WHZ_CYC + imax(DW_CYC, 1));
    localparam int SETUP_CYC = imax(1, AW_CYC - PULSE_CYC);
    localparam int REC_CYC   = imax(1, WC_CYC - SETUP_CYC - PULSE_CYC);
    localparam int CNT_W     = bits_for(imax(PULSE_CYC, imax(SETUP_CYC, REC_CYC)));

    logic capture, ce_act, we_act, drive;
    logic [DATA_W-1:0] data_q;

    sram_wr_fsm #(
        .SETUP_CYC (SETUP_CYC),
        .PULSE_CYC (PULSE_CYC),
        .REC_CYC   (REC_CYC),
        .WHZ_CYC   (WHZ_CYC),
        .CNT_W     (CNT_W)
    ) u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .req     (req),
        .capture (capture),
        .ce_act  (ce_act),
        .we_act  (we_act),
        .drive   (drive),
        .done    (done)
    );

    sram_wr_dpath #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) u_dp (
        .clk      (clk),
        .rst_n    (rst_n),
        .capture  (capture),
        .ce_act   (ce_act),
        .req_addr (req_addr),
        .req_data (req_data),
        .req_be   (req_be),
        .wide_sel (wide_sel),
        .addr_q   (sram_addr),
        .data_q   (data_q),
        .ub_n     (sram_ub_n),
        .lb_n     (sram_lb_n)
    );

    assign sram_ce1_n = !ce_act;
    assign sram_cs2   = ce_act;
    assign sram_we_n  = !we_act;
    assign sram_doe   = drive;
    assign sram_dout  = drive ? data_q : '0;

endmodule

// File: rtl/sram_wr_seq_chk.sv
module sram_wr_seq_chk #(
    parameter int ADDR_W    = 18,
    parameter int WP_CYC    = 6,
    parameter int WHZ_CYC   = 3,
    parameter int DW_CYC    = 4,
    parameter int WC_CYC    = 9
) (
    input logic              clk,
    input logic              rst_n,
    input logic              done,
    input logic [ADDR_W-1:0] sram_addr,
    input logic              sram_ce1_n,
    input logic              sram_cs2,
    input logic              sram_we_n,
    input logic              sram_ub_n,
    input logic              sram_lb_n,
    input logic              sram_doe
);

    logic [15:0] we_low_cnt, doe_cnt, addr_age;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            we_low_cnt <= '0;
            doe_cnt    <= '0;
            addr_age   <= 16'hFFFF;
        end else begin
            we_low_cnt <= !sram_we_n ? we_low_cnt + 1'b1 : '0;
            doe_cnt    <= sram_doe   ? doe_cnt + 1'b1    : '0;
            if (sram_addr != $past(sram_addr)) addr_age <= 16'd1;
            else if (addr_age != 16'hFFFF)     addr_age <= addr_age + 1'b1;
        end
    end

    p_strobe_in_select_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !sram_we_n |-> (!sram_ce1_n && sram_cs2));

    p_strobe_ends_first_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sram_we_n) |-> !sram_ce1_n);

    p_pulse_width_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sram_we_n) |-> (we_low_cnt >= 16'(WP_CYC)));

    p_addr_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!sram_ce1_n && $past(!sram_ce1_n)) |-> $stable(sram_addr));

    p_bsel_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
        sram_ce1_n |-> (sram_ub_n && sram_lb_n));

    p_drive_in_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
        sram_doe |-> !sram_we_n);

    p_drive_after_hiz_r6: assert property (@(posedge clk) disable iff (!rst_n)
        sram_doe |-> (we_low_cnt >= 16'(WHZ_CYC)));

    p_data_window_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sram_doe) |-> (doe_cnt >= 16'(DW_CYC)));

    p_done_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    p_done_deselected_r7: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> sram_ce1_n);

    p_cycle_spacing_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (sram_addr != $past(sram_addr)) |-> (addr_age >= 16'(WC_CYC)));

endmodule

bind sram_wr_seq sram_wr_seq_chk #(
    .ADDR_W  (ADDR_W),
    .WP_CYC  (WP_CYC),
    .WHZ_CYC (WHZ_CYC),
    .DW_CYC  (DW_CYC),
    .WC_CYC  (WC_CYC)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .done       (done),
    .sram_addr  (sram_addr),
    .sram_ce1_n (sram_ce1_n),
    .sram_cs2   (sram_cs2),
    .sram_we_n  (sram_we_n),
    .sram_ub_n  (sram_ub_n),
    .sram_lb_n  (sram_lb_n),
    .sram_doe   (sram_doe)
);

// File: tb/sim_sram_wr_seq.sv
module sim_sram_wr_seq;

    localparam int AW = 18;
    localparam int DW = 16;
    // expected timing at a 10 ns clock, from the requirements
    localparam int E_CE_LOW  = 9;
    localparam int E_WE_LOW  = 7;
    localparam int E_WE_AT   = 2;   // sample index of first strobe-low cycle
    localparam int E_DOE_AT  = 5;   // first driven sample (3 cycles of hi-Z)
    localparam int E_DOE_LEN = 4;
    localparam int E_DONE_AT = 10;

    typedef struct packed {
        logic [AW-1:0] addr;
        logic [DW-1:0] data;
        logic [1:0]    be;
        logic          wide;
        logic          ub_n;
        logic          lb_n;
    } vec_t;

    localparam vec_t VECS [6] = '{
        '{addr: 18'h00000, data: 16'h1234, be: 2'b11, wide: 1'b1, ub_n: 1'b0, lb_n: 1'b0},
        '{addr: 18'h3FFFF, data: 16'hA5A5, be: 2'b01, wide: 1'b1, ub_n: 1'b1, lb_n: 1'b0},
        '{addr: 18'h15555, data: 16'h5A5A, be: 2'b10, wide: 1'b1, ub_n: 1'b0, lb_n: 1'b1},
        '{addr: 18'h2AAAA, data: 16'hFFFF, be: 2'b11, wide: 1'b0, ub_n: 1'b1, lb_n: 1'b1},
        '{addr: 18'h00F0F, data: 16'h0000, be: 2'b01, wide: 1'b0, ub_n: 1'b1, lb_n: 1'b1},
        '{addr: 18'h12345, data: 16'hC3C3, be: 2'b00, wide: 1'b1, ub_n: 1'b1, lb_n: 1'b1}
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic [DW-1:0] req_data = '0;
    logic [1:0]    req_be = '0;
    logic          wide_sel = 1'b0;
    logic          done;
    logic [AW-1:0] sram_addr;
    logic          sram_ce1_n, sram_cs2, sram_we_n, sram_ub_n, sram_lb_n, sram_doe;
    logic [DW-1:0] sram_dout;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    sram_wr_seq u0 (
        .clk        (clk),
        .rst_n      (rst_n),
        .req        (req),
        .req_addr   (req_addr),
        .req_data   (req_data),
        .req_be     (req_be),
        .wide_sel   (wide_sel),
        .done       (done),
        .sram_addr  (sram_addr),
        .sram_ce1_n (sram_ce1_n),
        .sram_cs2   (sram_cs2),
        .sram_we_n  (sram_we_n),
        .sram_ub_n  (sram_ub_n),
        .sram_lb_n  (sram_lb_n),
        .sram_dout  (sram_dout),
        .sram_doe   (sram_doe)
    );

    task automatic check(input bit ok, input string rq, input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", rq, act, exp);
        end
    endtask

    // issue one request and watch 12 cycles; stray_req raises req again mid-cycle
    task automatic run_write(input vec_t v, input bit stray_req);
        int ce_n = 0, we_n = 0, doe_n = 0, we_first = 0, doe_first = 0, done_at = 0;
        int ce_first = 0, bsel_bad = 0, addr_bad = 0, data_bad = 0, sel_bad = 0;
        int overlap = 0, done_ce_bad = 0, done_cnt = 0;
        @(negedge clk);
        req = 1'b1; req_addr = v.addr; req_data = v.data; req_be = v.be; wide_sel = v.wide;
        for (int i = 1; i <= 12; i++) begin
            @(negedge clk);
            req = (stray_req && i == 3);
            if (stray_req && i == 3) begin
                req_addr = ~v.addr; req_data = ~v.data;
            end
            if (!sram_ce1_n) begin
                ce_n++;
                if (ce_first == 0) ce_first = i;
                if (sram_addr != v.addr) addr_bad++;
                if ({sram_ub_n, sram_lb_n} != {v.ub_n, v.lb_n}) bsel_bad++;
                if (!sram_cs2) sel_bad++;
            end else if (!sram_ub_n || !sram_lb_n) bsel_bad++;
            if (!sram_we_n) begin
                we_n++;
                if (we_first == 0) we_first = i;
                if (sram_ce1_n) sel_bad++;
            end
            if (sram_doe) begin
                doe_n++;
                if (doe_first == 0) doe_first = i;
                if (sram_dout != v.data) data_bad++;
                if (sram_we_n) overlap++;
            end
            if (done) begin
                done_cnt++;
                if (done_at == 0) done_at = i;
                if (!sram_ce1_n) done_ce_bad++;
                if (sram_addr != v.addr) addr_bad++;
            end
        end
        check(ce_first == 1 && ce_n == E_CE_LOW, "R3 ce low length", ce_n, E_CE_LOW);
        check(we_first == E_WE_AT, "R3 strobe starts after setup", we_first, E_WE_AT);
        check(we_n == E_WE_LOW, "R2 strobe width", we_n, E_WE_LOW);
        check(sel_bad == 0, "R1 strobe only inside select", sel_bad, 0);
        check(addr_bad == 0, "R4 address held", addr_bad, 0);
        check(bsel_bad == 0, "R5 byte selects", bsel_bad, 0);
        check(doe_first == E_DOE_AT && doe_n == E_DOE_LEN, "R6 drive window",
              doe_first * 100 + doe_n, E_DOE_AT * 100 + E_DOE_LEN);
        check(overlap == 0 && data_bad == 0, "R6 data driven only in pulse",
              overlap + data_bad, 0);
        check(done_at == E_DONE_AT && done_cnt == 1 && done_ce_bad == 0,
              "R7 done pulse", done_at * 100 + done_cnt, E_DONE_AT * 100 + 1);
        if (stray_req)
            check(ce_n == E_CE_LOW && done_cnt == 1, "R8 busy request ignored", ce_n, E_CE_LOW);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R9 reset state
        check(sram_ce1_n && sram_we_n && !sram_cs2 && sram_ub_n && sram_lb_n && !sram_doe && !done,
              "R9 reset outputs",
              {sram_ce1_n, sram_we_n, sram_cs2, sram_ub_n, sram_lb_n, sram_doe, done}, 7'b1101100);
        rst_n = 1'b1;
        @(negedge clk);
        check(sram_ce1_n && !done, "R9 idle after reset", sram_ce1_n, 1);

        foreach (VECS[k]) run_write(VECS[k], 1'b0);

        // R8 request during the pulse: address and data must stay the first request's
        run_write(VECS[1], 1'b1);
        for (int i = 0; i < 5; i++) begin
            @(negedge clk);
            check(sram_ce1_n && sram_addr == VECS[1].addr, "R8 no extra cycle",
                  sram_addr, VECS[1].addr);
        end

        // R10 back-to-back: request held high, next cycle starts only after done
        begin
            int gap = 0;
            bit seen_lo = 1'b0;
            @(negedge clk);
            req = 1'b1; req_addr = 18'h00111; req_data = 16'h1111; req_be = 2'b11; wide_sel = 1'b1;
            @(negedge clk);
            req_addr = 18'h00222;
            for (int i = 0; i < 20; i++) begin
                @(negedge clk);
                gap++;
                if (sram_addr == 18'h00222 && !seen_lo) begin
                    seen_lo = 1'b1;
                    check(gap >= 9, "R10 address spacing", gap, 9);
                end
            end
            req = 1'b0;
            check(seen_lo, "R10 second cycle started", seen_lo, 1);
            repeat (12) @(negedge clk);
        end

        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

endmodule